// File: doc/BRIEF.md
# CAN Frame Field Parser

The parser sits behind a bit destuffer on the receive side of a CAN controller. For each frame bit it gets one strobe with the bit value and the frame-bit index, counted without stuff bits and starting at 0 for the start-of-frame bit. It builds the identifier, the frame format, the remote flag, the reserved bits, the length code, up to eight data bytes, the received CRC and the acknowledge state into registers. It runs its own CRC over the frame and raises one error flag for each class of malformed content.

The positions of the fields that follow the arbitration field are not fixed. They come from the format bit and the length code once those have been received. The parser reports the index of the last data bit back to the destuffer, because stuffing stops after the CRC field. One trailer path checks the CRC, the delimiters, the acknowledge slot and end of frame for both frame formats. A pulse marks a clean frame at the end of end of frame, and a second pulse marks the end of the three intermission bits.

Top module: `can_field_parser`

## Requirements
- R1: After reset, frame_valid and frame_done are 0, err_flags is 0 and last_data_idx is all ones.
- R2: The bit at index 0 (start of frame) must be 0. A 1 there sets err_flags[0].
- R3: Indices 1 to 11 carry id_std[10:0], most significant bit first. If id_std[10:4] are all 1, err_flags[1] is set.
- R4: Index 13 is the format bit: 0 gives ide=0 (standard) and 1 gives ide=1 (extended). Index 12 is the remote flag (rtr) in standard frames and the srr output in extended frames. srr reads 0 in standard frames.
- R5: In a standard frame, index 14 is reserved bit rsv0, indices 15 to 18 are dlc (MSB first) and data starts at 19. last_data_idx becomes 18 + 8*N, where N is the data byte count.
- R6: In an extended frame, indices 14 to 31 are id_ext[17:0] (MSB first), 32 is rtr, 33 is rsv1, 34 is rsv0, 35 to 38 are dlc and data starts at 39. last_data_idx becomes 38 + 8*N, and id_full = {id_std, id_ext}.
- R7: N is 0 in a remote frame (rtr=1), whatever dlc holds. Otherwise N is dlc, capped at 8. A dlc above 8 sets err_flags[2].
- R8: Data bytes arrive MSB first. Byte k is placed on data[8k+7:8k], and bytes that were not received read 0.
- R9: The CRC uses polynomial 0x4599 (15 bits) with a zero start value and covers indices 0 to last_data_idx. The next 15 bits appear on crc_rx (MSB first), and a mismatch sets err_flags[3].
- R10: A 0 in the CRC delimiter (last+16) sets err_flags[4]. A 0 in the ACK delimiter (last+18) sets err_flags[5]. Any 0 in end of frame (last+19 to last+25) sets err_flags[6]. ack is 1 when the slot (last+17) is 0, and a 1 in the slot flags no error.
- R11: A 1 in a reserved bit is shown on rsv0 or rsv1 and sets no error flag.
- R12: frame_valid pulses for one cycle after the bit at last+25 when all error flags, including that bit's own end-of-frame check, are clear. frame_done pulses for one cycle after the bit at last+28.
- R13: A bit at index 0 clears all fields, error flags and the received CRC. Between strobes, fields and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | One-cycle strobe for a destuffed frame bit |
| bit_val | input | 1 | Bit value, 0 = dominant |
| bit_idx | input | IDX_W | Frame-bit index of the strobed bit |
| last_data_idx | output | IDX_W | Index of the last data bit, all ones until known |
| id_std | output | 11 | Base identifier |
| id_ext | output | 18 | Identifier extension |
| id_full | output | 29 | Base identifier above the extension |
| ide | output | 1 | Extended format |
| rtr | output | 1 | Remote frame |
| srr | output | 1 | Substitute remote bit of extended frames |
| rsv0 | output | 1 | Reserved bit 0 |
| rsv1 | output | 1 | Reserved bit 1 (extended only) |
| dlc | output | 4 | Data length code |
| data | output | 64 | Data bytes, byte k on bits 8k+7:8k |
| crc_rx | output | 15 | Received CRC sequence |
| ack | output | 1 | Acknowledge slot was dominant |
| err_flags | output | 7 | SOF, ID, DLC, CRC, CRC delim, ACK delim, EOF |
| frame_valid | output | 1 | Clean frame pulse |
| frame_done | output | 1 | End of intermission pulse |

## Verification
The assertions check on every cycle that a frame_valid pulse never coincides with an error flag or with frame_done and lasts one cycle, and that frame_done follows a bit strobe. They also check that fields and flags do not move without a strobe, that last_data_idx stays within the legal range once it is known, and that the length flag rises only for a code above 8. Only the bench's frames can show that fields land in the right bits for each format, that remote and oversize length codes move the trailer to the right index, and that the CRC matches. The bench frames also show the effect of each corrupted delimiter or end-of-frame bit.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;
   localparam int ID_W      = 11;
   localparam int EID_W     = 18;
   localparam int DLC_W     = 4;
   localparam int CRC_W     = 15;
   localparam int MAX_BYTES = 8;
   localparam int DATA_W    = MAX_BYTES * 8;
   localparam int ERR_W     = 7;

   // field positions fixed by the format
   localparam int POS_ID_LAST  = 11;
   localparam int POS_BIT12    = 12;
   localparam int POS_IDE      = 13;
   localparam int STD_DLC_END  = 18;
   localparam int EXT_EID_LAST = 31;
   localparam int EXT_RTR      = 32;
   localparam int EXT_RSV1     = 33;
   localparam int EXT_RSV0     = 34;
   localparam int EXT_DLC_END  = 38;
   localparam int STD_RSV0     = 14;

   // trailer offsets relative to the last data bit
   localparam int T_CRC_LAST  = 15;
   localparam int T_CRC_DELIM = 16;
   localparam int T_ACK_SLOT  = 17;
   localparam int T_ACK_DELIM = 18;
   localparam int T_EOF_FIRST = 19;
   localparam int T_EOF_LAST  = 25;
   localparam int T_IFS_LAST  = 28;

   // error flag positions
   localparam int E_SOF       = 0;
   localparam int E_ID        = 1;
   localparam int E_DLC       = 2;
   localparam int E_CRC       = 3;
   localparam int E_CRC_DELIM = 4;
   localparam int E_ACK_DELIM = 5;
   localparam int E_EOF       = 6;
endpackage

// File: rtl/can_fp_crc.sv
module can_fp_crc #(
   parameter int            W    = 15,
   parameter logic [W-1:0]  POLY = 15'h4599
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic [W-1:0] base;
   logic         fb;
   logic [W-1:0] nxt;

   assign base = clr ? '0 : crc;
   assign fb   = base[W-1] ^ din;
   assign nxt  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc <= '0;
      else if (en) crc <= nxt;
   end
endmodule

// File: rtl/can_fp_header.sv
module can_fp_header
   import can_fp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_val,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic [ID_W-1:0]   id_q,
   output logic [EID_W-1:0]  eid_q,
   output logic              ide_q,
   output logic              bit12_q,
   output logic              rtr_ext_q,
   output logic              rsv0_q,
   output logic              rsv1_q,
   output logic [DLC_W-1:0]  dlc_q,
   output logic [DATA_W-1:0] data_o,
   output logic [IDX_W-1:0]  last_q,
   output logic              known_q,
   output logic              err_sof,
   output logic              err_id,
   output logic              err_dlc
);
   logic              start;
   logic [IDX_W-1:0]  dlc_first;
   logic [IDX_W-1:0]  dlc_end;
   logic [DLC_W-1:0]  dlc_new;
   logic              rtr_eff;
   logic [DLC_W-1:0]  nbytes;
   logic [IDX_W-1:0]  last_calc;
   logic              in_dlc;
   logic              in_data;
   logic [IDX_W-1:0]  off;

   assign start     = bit_valid && (bit_idx == '0);
   assign dlc_first = ide_q ? IDX_W'(EXT_DLC_END - 3) : IDX_W'(STD_DLC_END - 3);
   assign dlc_end   = ide_q ? IDX_W'(EXT_DLC_END) : IDX_W'(STD_DLC_END);
   assign dlc_new   = {dlc_q[DLC_W-2:0], bit_val};
   assign rtr_eff   = ide_q ? rtr_ext_q : bit12_q;
   assign nbytes    = rtr_eff ? '0 :
                      (dlc_new > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc_new;
   assign last_calc = dlc_end + IDX_W'({nbytes, 3'b000});
   assign in_dlc    = bit_valid && !known_q && (bit_idx >= dlc_first) && (bit_idx <= dlc_end)
                      && (bit_idx > IDX_W'(POS_IDE));
   assign in_data   = bit_valid && known_q && (bit_idx > dlc_end) && (bit_idx <= last_q);
   assign off       = bit_idx - dlc_end - IDX_W'(1);

   // arbitration and control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q      <= '0;
         eid_q     <= '0;
         ide_q     <= 1'b0;
         bit12_q   <= 1'b0;
         rtr_ext_q <= 1'b0;
         rsv0_q    <= 1'b0;
         rsv1_q    <= 1'b0;
         err_sof   <= 1'b0;
         err_id    <= 1'b0;
      end else if (start) begin
         id_q      <= '0;
         eid_q     <= '0;
         ide_q     <= 1'b0;
         bit12_q   <= 1'b0;
         rtr_ext_q <= 1'b0;
         rsv0_q    <= 1'b0;
         rsv1_q    <= 1'b0;
         err_sof   <= bit_val;
         err_id    <= 1'b0;
      end else if (bit_valid) begin
         if (bit_idx <= IDX_W'(POS_ID_LAST)) begin
            id_q <= {id_q[ID_W-2:0], bit_val};
            // the seven upper bits are frame bits 1..7, already held in id_q[9:3]
            if (bit_idx == IDX_W'(POS_ID_LAST) && (&id_q[ID_W-2:3]))
               err_id <= 1'b1;
         end else if (bit_idx == IDX_W'(POS_BIT12)) begin
            bit12_q <= bit_val;
         end else if (bit_idx == IDX_W'(POS_IDE)) begin
            ide_q <= bit_val;
         end else if (!ide_q) begin
            if (bit_idx == IDX_W'(STD_RSV0)) rsv0_q <= bit_val;
         end else begin
            if (bit_idx <= IDX_W'(EXT_EID_LAST)) eid_q <= {eid_q[EID_W-2:0], bit_val};
            else if (bit_idx == IDX_W'(EXT_RTR))  rtr_ext_q <= bit_val;
            else if (bit_idx == IDX_W'(EXT_RSV1)) rsv1_q <= bit_val;
            else if (bit_idx == IDX_W'(EXT_RSV0)) rsv0_q <= bit_val;
         end
      end
   end

   // length code and dynamic data-field end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dlc_q   <= '0;
         last_q  <= '1;
         known_q <= 1'b0;
         err_dlc <= 1'b0;
      end else if (start) begin
         dlc_q   <= '0;
         last_q  <= '1;
         known_q <= 1'b0;
         err_dlc <= 1'b0;
      end else if (in_dlc) begin
         dlc_q <= dlc_new;
         if (bit_idx == dlc_end) begin
            known_q <= 1'b1;
            last_q  <= last_calc;
            err_dlc <= (dlc_new > DLC_W'(MAX_BYTES));
         end
      end
   end

   // one register per data byte, MSB first
   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (start)
            byte_q <= '0;
         else if (in_data && (off[5:3] == 3'(g)))
            byte_q[~off[2:0]] <= bit_val;
      end
      assign data_o[8*g +: 8] = byte_q;
   end
endmodule

// File: rtl/can_fp_tail.sv
module can_fp_tail
   import can_fp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_val,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic [IDX_W-1:0] last_idx,
   input  logic             known,
   input  logic [CRC_W-1:0] crc_calc,
   output logic [CRC_W-1:0] crc_rx,
   output logic             ack,
   output logic             err_crc,
   output logic             err_crc_delim,
   output logic             err_ack_delim,
   output logic             err_eof,
   output logic             eof_end,
   output logic             frame_done
);
   logic             start;
   logic             in_tail;
   logic [IDX_W-1:0] rel;
   logic [CRC_W-1:0] crc_nxt;

   assign start   = bit_valid && (bit_idx == '0);
   assign in_tail = bit_valid && known && (bit_idx > last_idx);
   assign rel     = bit_idx - last_idx;
   assign crc_nxt = {crc_rx[CRC_W-2:0], bit_val};
   assign eof_end = in_tail && (rel == IDX_W'(T_EOF_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_rx        <= '0;
         ack           <= 1'b0;
         err_crc       <= 1'b0;
         err_crc_delim <= 1'b0;
         err_ack_delim <= 1'b0;
         err_eof       <= 1'b0;
         frame_done    <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (start) begin
            crc_rx        <= '0;
            ack           <= 1'b0;
            err_crc       <= 1'b0;
            err_crc_delim <= 1'b0;
            err_ack_delim <= 1'b0;
            err_eof       <= 1'b0;
         end else if (in_tail) begin
            if (rel <= IDX_W'(T_CRC_LAST)) begin
               crc_rx <= crc_nxt;
               if (rel == IDX_W'(T_CRC_LAST)) err_crc <= (crc_nxt != crc_calc);
            end else if (rel == IDX_W'(T_CRC_DELIM)) begin
               err_crc_delim <= !bit_val;
            end else if (rel == IDX_W'(T_ACK_SLOT)) begin
               ack <= !bit_val;
            end else if (rel == IDX_W'(T_ACK_DELIM)) begin
               err_ack_delim <= !bit_val;
            end else if (rel <= IDX_W'(T_EOF_LAST)) begin
               if (!bit_val) err_eof <= 1'b1;
            end else if (rel == IDX_W'(T_IFS_LAST)) begin
               frame_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
   import can_fp_pkg::*;
#(
   parameter int               IDX_W    = 8,
   parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_val,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic [IDX_W-1:0]  last_data_idx,
   output logic [ID_W-1:0]   id_std,
   output logic [EID_W-1:0]  id_ext,
   output logic [ID_W+EID_W-1:0] id_full,
   output logic              ide,
   output logic              rtr,
   output logic              srr,
   output logic              rsv0,
   output logic              rsv1,
   output logic [DLC_W-1:0]  dlc,
   output logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_rx,
   output logic              ack,
   output logic [ERR_W-1:0]  err_flags,
   output logic              frame_valid,
   output logic              frame_done
);
   // longest frame index: extended, eight bytes, trailer and intermission
   localparam int MAX_IDX = EXT_DLC_END + DATA_W + T_IFS_LAST;

   if ((1 << IDX_W) <= MAX_IDX) begin : g_bad_idx_w
      $error("IDX_W too narrow for the longest frame");
   end
   if (CRC_POLY[0] == 1'b0) begin : g_bad_poly
      $error("CRC_POLY needs a constant term");
   end

   logic             bit12_q, rtr_ext_q, known_q;
   logic             err_sof, err_id, err_dlc;
   logic             err_crc, err_crc_delim, err_ack_delim, err_eof;
   logic             eof_end;
   logic [CRC_W-1:0] crc_calc;
   logic             crc_en;
   logic             fv_q;

   can_fp_header #(.IDX_W(IDX_W)) hdr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_val   (bit_val),
      .bit_idx   (bit_idx),
      .id_q      (id_std),
      .eid_q     (id_ext),
      .ide_q     (ide),
      .bit12_q   (bit12_q),
      .rtr_ext_q (rtr_ext_q),
      .rsv0_q    (rsv0),
      .rsv1_q    (rsv1),
      .dlc_q     (dlc),
      .data_o    (data),
      .last_q    (last_data_idx),
      .known_q   (known_q),
      .err_sof   (err_sof),
      .err_id    (err_id),
      .err_dlc   (err_dlc)
   );

   // last_data_idx is all ones until the length is known, so this covers SOF..data
   assign crc_en = bit_valid && (bit_idx <= last_data_idx);

   can_fp_crc #(.W(CRC_W), .POLY(CRC_POLY)) crc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (crc_en),
      .clr   (bit_idx == '0),
      .din   (bit_val),
      .crc   (crc_calc)
   );

   can_fp_tail #(.IDX_W(IDX_W)) tail_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_valid     (bit_valid),
      .bit_val       (bit_val),
      .bit_idx       (bit_idx),
      .last_idx      (last_data_idx),
      .known         (known_q),
      .crc_calc      (crc_calc),
      .crc_rx        (crc_rx),
      .ack           (ack),
      .err_crc       (err_crc),
      .err_crc_delim (err_crc_delim),
      .err_ack_delim (err_ack_delim),
      .err_eof       (err_eof),
      .eof_end       (eof_end),
      .frame_done    (frame_done)
   );

   always_comb begin
      err_flags              = '0;
      err_flags[E_SOF]       = err_sof;
      err_flags[E_ID]        = err_id;
      err_flags[E_DLC]       = err_dlc;
      err_flags[E_CRC]       = err_crc;
      err_flags[E_CRC_DELIM] = err_crc_delim;
      err_flags[E_ACK_DELIM] = err_ack_delim;
      err_flags[E_EOF]       = err_eof;
   end

   assign rtr     = ide ? rtr_ext_q : bit12_q;
   assign srr     = ide & bit12_q;
   assign id_full = {id_std, id_ext};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fv_q <= 1'b0;
      else        fv_q <= eof_end && bit_val && (err_flags == '0);
   end
   assign frame_valid = fv_q;
endmodule

// File: rtl/can_field_parser_chk.sv
module can_field_parser_chk
   import can_fp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_valid,
   input logic [IDX_W-1:0]  last_data_idx,
   input logic [ID_W-1:0]   id_std,
   input logic [DLC_W-1:0]  dlc,
   input logic [DATA_W-1:0] data,
   input logic [ERR_W-1:0]  err_flags,
   input logic              frame_valid,
   input logic              frame_done
);
   p_valid_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> (err_flags == '0));

   p_valid_not_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> !frame_done);

   p_valid_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   p_done_after_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(bit_valid));

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> ($stable(id_std) && $stable(dlc) && $stable(data) && $stable(err_flags)));

   p_last_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_data_idx != '1) |-> ((last_data_idx >= IDX_W'(STD_DLC_END)) &&
                                 (last_data_idx <= IDX_W'(EXT_DLC_END + DATA_W))));

   p_dlc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_DLC]) |-> (dlc > DLC_W'(MAX_BYTES)));
endmodule

bind can_field_parser can_field_parser_chk #(.IDX_W(IDX_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .bit_valid     (bit_valid),
   .last_data_idx (last_data_idx),
   .id_std        (id_std),
   .dlc           (dlc),
   .data          (data),
   .err_flags     (err_flags),
   .frame_valid   (frame_valid),
   .frame_done    (frame_done)
);

// File: tb/can_field_parser_tb_top.sv
module can_field_parser_tb_top;
   localparam int IDX_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_valid = 1'b0;
   logic             bit_val = 1'b1;
   logic [IDX_W-1:0] bit_idx = '0;
   logic [IDX_W-1:0] last_data_idx;
   logic [10:0]      id_std;
   logic [17:0]      id_ext;
   logic [28:0]      id_full;
   logic             ide, rtr, srr, rsv0, rsv1, ack;
   logic [3:0]       dlc;
   logic [63:0]      data;
   logic [14:0]      crc_rx;
   logic [6:0]       err_flags;
   logic             frame_valid, frame_done;

   always #10 clk = ~clk;

   can_field_parser #(.IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
      .bit_idx(bit_idx), .last_data_idx(last_data_idx), .id_std(id_std),
      .id_ext(id_ext), .id_full(id_full), .ide(ide), .rtr(rtr), .srr(srr),
      .rsv0(rsv0), .rsv1(rsv1), .dlc(dlc), .data(data), .crc_rx(crc_rx),
      .ack(ack), .err_flags(err_flags), .frame_valid(frame_valid),
      .frame_done(frame_done)
   );

   int n_chk = 0;
   int n_bad = 0;
   int fv_total = 0;
   int fd_total = 0;

   always @(negedge clk) begin
      if (frame_valid) fv_total++;
      if (frame_done)  fd_total++;
   end

   // frame under construction
   logic        fb [0:199];
   int          fn;
   int          exp_last;
   logic [14:0] exp_crc;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic v);
      fb[fn] = v;
      fn++;
   endtask

   task automatic build(input bit ext, input bit [10:0] id, input bit [17:0] eid,
                        input bit rem, input bit [3:0] len, input bit [63:0] d,
                        input bit r0, input bit r1);
      int nb;
      logic [14:0] c;
      fn = 0;
      push(1'b0);
      for (int i = 10; i >= 0; i--) push(id[i]);
      push(ext ? 1'b1 : rem);
      push(ext);
      if (ext) begin
         for (int i = 17; i >= 0; i--) push(eid[i]);
         push(rem);
         push(r1);
         push(r0);
      end else begin
         push(r0);
      end
      for (int i = 3; i >= 0; i--) push(len[i]);
      nb = rem ? 0 : ((len > 8) ? 8 : int'(len));
      for (int k = 0; k < nb; k++)
         for (int b = 7; b >= 0; b--) push(d[8*k+b]);
      exp_last = (ext ? 38 : 18) + 8*nb;
      c = '0;
      for (int i = 0; i < fn; i++) begin
         logic f;
         f = c[14] ^ fb[i];
         c = {c[13:0], 1'b0} ^ (f ? 15'h4599 : 15'h0);
      end
      exp_crc = c;
      for (int i = 14; i >= 0; i--) push(c[i]);
      push(1'b1);
      push(1'b0);
      push(1'b1);
      for (int i = 0; i < 10; i++) push(1'b1);
   endtask

   int fv0, fd0;

   task automatic send();
      fv0 = fv_total;
      fd0 = fd_total;
      for (int i = 0; i < fn; i++) begin
         @(negedge clk);
         bit_valid = 1'b1;
         bit_val   = fb[i];
         bit_idx   = IDX_W'(i);
         @(negedge clk);
         bit_valid = 1'b0;
         bit_val   = 1'b1;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 frame_valid", 64'(frame_valid), 0);
      check("R1 frame_done", 64'(frame_done), 0);
      check("R1 err_flags", 64'(err_flags), 0);
      check("R1 last_data_idx", 64'(last_data_idx), 64'hFF);
   endtask

   task automatic t_std_data();
      build(0, 11'h123, 0, 0, 4'd2, 64'h55AA, 0, 0);
      send();
      check("R3 id_std", 64'(id_std), 64'h123);
      check("R4 ide std", 64'(ide), 0);
      check("R4 rtr std", 64'(rtr), 0);
      check("R4 srr std", 64'(srr), 0);
      check("R5 dlc", 64'(dlc), 2);
      check("R5 last std", 64'(last_data_idx), 34);
      check("R8 data std", data, 64'h55AA);
      check("R9 crc_rx", 64'(crc_rx), 64'(exp_crc));
      check("R10 ack", 64'(ack), 1);
      check("R13 err cleared", 64'(err_flags), 0);
      check("R12 valid count", 64'(fv_total - fv0), 1);
      check("R12 done count", 64'(fd_total - fd0), 1);
   endtask

   task automatic t_ext_data();
      build(1, 11'h0A5, 18'h2BCDE, 0, 4'd8, 64'h0123456789ABCDEF, 0, 0);
      send();
      check("R4 ide ext", 64'(ide), 1);
      check("R4 srr ext", 64'(srr), 1);
      check("R6 rtr ext", 64'(rtr), 0);
      check("R6 id_ext", 64'(id_ext), 64'h2BCDE);
      check("R6 id_full", 64'(id_full), {35'h0, 11'h0A5, 18'h2BCDE});
      check("R6 last ext", 64'(last_data_idx), 102);
      check("R8 data ext", data, 64'h0123456789ABCDEF);
      check("R12 valid ext", 64'(fv_total - fv0), 1);
   endtask

   task automatic t_remote();
      build(0, 11'h3C1, 0, 1, 4'd4, 64'h0, 0, 0);
      send();
      check("R7 rtr remote", 64'(rtr), 1);
      check("R7 last remote", 64'(last_data_idx), 18);
      check("R7 dlc remote", 64'(dlc), 4);
      check("R8 no data remote", data, 0);
      check("R12 valid remote", 64'(fv_total - fv0), 1);
   endtask

   task automatic t_reserved();
      build(1, 11'h011, 18'h00001, 0, 4'd1, 64'h7E, 1, 1);
      send();
      check("R11 rsv0", 64'(rsv0), 1);
      check("R11 rsv1", 64'(rsv1), 1);
      check("R11 no error", 64'(err_flags), 0);
      check("R8 one byte, rest zero", data, 64'h7E);
      check("R11 valid", 64'(fv_total - fv0), 1);
   endtask

   task automatic t_crc_err();
      build(0, 11'h2F0, 0, 0, 4'd1, 64'hC3, 0, 0);
      fb[exp_last + 3] = ~fb[exp_last + 3];
      send();
      check("R9 crc error", 64'(err_flags), 64'h08);
      check("R12 no valid on crc error", 64'(fv_total - fv0), 0);
      check("R12 done on crc error", 64'(fd_total - fd0), 1);
   endtask

   task automatic t_id_err();
      build(0, 11'h7F0, 0, 0, 4'd0, 64'h0, 0, 0);
      send();
      check("R3 id recessive error", 64'(err_flags), 64'h02);
      check("R3 no valid", 64'(fv_total - fv0), 0);
   endtask

   task automatic t_dlc_err();
      build(0, 11'h100, 0, 0, 4'd9, 64'hF0E1D2C3B4A59687, 0, 0);
      send();
      check("R7 dlc error", 64'(err_flags), 64'h04);
      check("R7 dlc value", 64'(dlc), 9);
      check("R7 last capped", 64'(last_data_idx), 82);
      check("R8 eight bytes", data, 64'hF0E1D2C3B4A59687);
      check("R7 no valid", 64'(fv_total - fv0), 0);
   endtask

   task automatic t_tail_err();
      build(0, 11'h055, 0, 0, 4'd0, 64'h0, 0, 0);
      fb[exp_last + 16] = 1'b0;
      fb[exp_last + 17] = 1'b1;
      fb[exp_last + 18] = 1'b0;
      fb[exp_last + 22] = 1'b0;
      send();
      check("R10 tail errors", 64'(err_flags), 64'h70);
      check("R10 nack", 64'(ack), 0);
      check("R12 no valid tail", 64'(fv_total - fv0), 0);
   endtask

   task automatic t_last_eof();
      build(0, 11'h066, 0, 0, 4'd0, 64'h0, 0, 0);
      fb[exp_last + 25] = 1'b0;
      send();
      check("R10 last eof bit", 64'(err_flags), 64'h40);
      check("R12 no valid last eof", 64'(fv_total - fv0), 0);
   endtask

   task automatic t_nack_only();
      build(0, 11'h077, 0, 0, 4'd1, 64'h81, 0, 0);
      fb[exp_last + 17] = 1'b1;
      send();
      check("R10 nack no error", 64'(err_flags), 0);
      check("R10 ack low", 64'(ack), 0);
      check("R12 valid with nack", 64'(fv_total - fv0), 1);
   endtask

   task automatic t_sof_err();
      build(0, 11'h044, 0, 0, 4'd0, 64'h0, 0, 0);
      fb[0] = 1'b1;
      send();
      check("R2 sof error (crc also)", 64'(err_flags), 64'h09);
      check("R2 no valid", 64'(fv_total - fv0), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_std_data();
      t_crc_err();
      t_std_data();
      t_ext_data();
      t_remote();
      t_reserved();
      t_id_err();
      t_dlc_err();
      t_tail_err();
      t_last_eof();
      t_nack_only();
      t_sof_err();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=frame_done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule